// File: doc/BRIEF.md
# Sequential 16x16 Multiplier from Byte Products

This block multiplies two 16-bit operands and returns a 32-bit product, using a single shared 8 x 8 unsigned multiplier over several cycles. The block splits each operand into a high byte and a low byte. It forms the four byte-pair products one per cycle, in the order low×low, low(A)×high(B), high(A)×low(B), high×high. Each product is added into a 32-bit accumulator at a byte offset of 0, 8, 8 or 16 bits, and carries run through the full accumulator width.

A fifth cycle applies a correction that makes the result a two's-complement product when signed mode was requested. If operand B is negative, operand A is subtracted from the upper 16 bits of the result. If operand A is negative, operand B is subtracted from those bits. In unsigned mode this cycle subtracts nothing, so the latency is the same in both modes.

The caller pulses `start` with the operands and the mode. It then waits for the one-cycle `done` pulse and reads the product as four bytes. The product stays on the outputs until the next operation completes.

Top module: `seqmul16`

## Requirements
- R1: Reset is synchronous and active high. After reset, `busy` and `done` are 0 and all four result bytes are 0.
- R2: With `signed_mode` = 0 at the start, the 32-bit result equals the unsigned product of `op_a` and `op_b`, including every carry. The all-ones operands give 0xFFFE0001.
- R3: With `signed_mode` = 1 at the start, the result equals the 32-bit two's-complement product of the two operands read as signed 16-bit values. For example, 0x8000 × 0x8000 gives 0x40000000 and 0xFFFF × 0x0001 gives 0xFFFFFFFF.
- R4: The result is presented as four bytes. `res_b3` holds bits 31:24, `res_b2` holds bits 23:16, `res_b1` holds bits 15:8 and `res_b0` holds bits 7:0.
- R5: A `start` pulse seen on a clock edge while `busy` is 0 launches an operation. `busy` is 1 for exactly 5 clock cycles after that edge. A new `start` is accepted in the cycle where `done` is high.
- R6: While `busy` is 1, `start`, `op_a`, `op_b` and `signed_mode` have no effect. The pending operation returns the product of the operands captured at launch, and no extra completion follows from a start seen while busy.
- R7: `done` is high for exactly one cycle per operation, in the first cycle where `busy` is 0 again, and the result bytes already hold the new product in that cycle.
- R8: The result bytes change only in a cycle where `done` is high. While a following operation runs, the previous product stays on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, honoured only when idle |
| signed_mode | input | 1 | 1 selects a two's-complement product |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| res_b3 | output | 8 | Result bits 31:24 |
| res_b2 | output | 8 | Result bits 23:16 |
| res_b1 | output | 8 | Result bits 15:8 |
| res_b0 | output | 8 | Result bits 7:0 |

## Verification
The hardest case to reach from the ports is new stimulus arriving while an operation is in flight. To reach it, the driver raises `start` again with different operands and a flipped mode during the busy window. The scoreboard then requires the single next completion to carry the product captured at launch, after exactly five busy cycles.

The signed correction changes the result only when an operand has its top bit set. Carries out of the middle partial products appear only with large bytes. For that reason, the corner values 0, 1, 0x7FFF, 0x8000 and 0xFFFF are crossed in both modes before the random pairs. Operations are issued back to back in the done cycle, so the stability of the held result is observed while the next product is being formed.

// File: rtl/seqmul16_pkg.sv
package seqmul16_pkg;
  // Step of the multiply sequence; the order of the products is fixed.
  typedef enum logic [2:0] {
    PH_LL  = 3'd0,  // low A x low B,  offset 0
    PH_LH  = 3'd1,  // low A x high B, offset one half
    PH_HL  = 3'd2,  // high A x low B, offset one half
    PH_HH  = 3'd3,  // high A x high B, offset one word
    PH_FIX = 3'd4   // signed correction of the upper word
  } phase_t;

  localparam int unsigned NUM_STEPS = 5;
endpackage

// File: rtl/byte_mult.sv
module byte_mult #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  always_comb p = (2*W)'(x) * (2*W)'(y);
endmodule

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
  import seqmul16_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output logic   load,
  output logic   step_en,
  output logic   fin,
  output phase_t phase,
  output logic   busy,
  output logic   done
);
  logic run;

  assign load    = start && !run;
  assign step_en = run;
  assign fin     = run && (phase == PH_FIX);
  assign busy    = run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      phase <= PH_LL;
      done  <= 1'b0;
    end else begin
      done <= fin;
      if (load) begin
        run   <= 1'b1;
        phase <= PH_LL;
      end else if (run) begin
        if (phase == PH_FIX) begin
          run   <= 1'b0;
          phase <= PH_LL;
        end else begin
          phase <= phase_t'(phase + 3'd1);
        end
      end
    end
  end

  // Walk through the steps in order, one per cycle.
  a_r5_phase_walk: assert property (@(posedge clk) disable iff (rst)
    (run && phase != PH_FIX) |=> (run && phase == phase_t'($past(phase) + 3'd1)));
  // A start seen while running must not restart the sequence.
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    (run && start && phase != PH_FIX) |=> (phase != PH_LL));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!run && $past(run)));
endmodule

// File: rtl/seqmul_accum.sv
module seqmul_accum
  import seqmul16_pkg::*;
#(
  parameter int unsigned HW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            step_en,
  input  logic            fin,
  input  phase_t          phase,
  input  logic            sgn_in,
  input  logic [2*HW-1:0] a_in,
  input  logic [2*HW-1:0] b_in,
  output logic [4*HW-1:0] acc_nxt
);
  localparam int unsigned OW = 2 * HW;
  localparam int unsigned RW = 4 * HW;

  logic [OW-1:0] a_q, b_q;
  logic          sgn_q;
  logic [RW-1:0] acc;
  logic [HW-1:0] mx, my;
  logic [OW-1:0] pp;
  logic [RW-1:0] addend;
  logic [OW:0]   fix;
  logic [RW-1:0] fix_wide;

  byte_mult #(.W(HW)) u_bm (.x(mx), .y(my), .p(pp));

  // Pick the byte pair and its offset for the current step.
  always_comb begin
    mx     = a_q[HW-1:0];
    my     = b_q[HW-1:0];
    addend = '0;
    case (phase)
      PH_LL: begin
        mx = a_q[HW-1:0];  my = b_q[HW-1:0];
        addend = RW'(pp);
      end
      PH_LH: begin
        mx = a_q[HW-1:0];  my = b_q[OW-1:HW];
        addend = RW'(pp) << HW;
      end
      PH_HL: begin
        mx = a_q[OW-1:HW]; my = b_q[HW-1:0];
        addend = RW'(pp) << HW;
      end
      PH_HH: begin
        mx = a_q[OW-1:HW]; my = b_q[OW-1:HW];
        addend = RW'(pp) << OW;
      end
      default: addend = '0;
    endcase
  end

  // Two's-complement correction of the upper word.
  always_comb begin
    fix = '0;
    if (sgn_q && b_q[OW-1]) fix = fix + (OW+1)'(a_q);
    if (sgn_q && a_q[OW-1]) fix = fix + (OW+1)'(b_q);
    fix_wide = RW'(fix) << OW;
  end

  always_comb begin
    if (phase == PH_FIX) acc_nxt = acc - fix_wide;
    else                 acc_nxt = acc + addend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      sgn_q <= 1'b0;
      acc   <= '0;
    end else if (load) begin
      a_q   <= a_in;
      b_q   <= b_in;
      sgn_q <= sgn_in;
      acc   <= '0;
    end else if (step_en) begin
      acc <= acc_nxt;
    end
  end

  a_r6_ops_held: assert property (@(posedge clk) disable iff (rst)
    (step_en && $past(step_en)) |-> ($stable(a_q) && $stable(b_q) && $stable(sgn_q)));
  a_r2_unsigned_final: assert property (@(posedge clk) disable iff (rst)
    (fin && !sgn_q) |-> (acc_nxt == RW'(a_q) * RW'(b_q)));
  a_r3_signed_final: assert property (@(posedge clk) disable iff (rst)
    (fin && sgn_q) |-> ($signed(acc_nxt) ==
      $signed({{OW{a_q[OW-1]}}, a_q}) * $signed({{OW{b_q[OW-1]}}, b_q})));
endmodule

// File: rtl/seqmul16.sv
module seqmul16
  import seqmul16_pkg::*;
#(
  parameter int unsigned HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          signed_mode,
  input  logic [2*HW-1:0] op_a,
  input  logic [2*HW-1:0] op_b,
  output logic          busy,
  output logic          done,
  output logic [HW-1:0] res_b3,
  output logic [HW-1:0] res_b2,
  output logic [HW-1:0] res_b1,
  output logic [HW-1:0] res_b0
);
  localparam int unsigned RW = 4 * HW;

  logic          load, step_en, fin;
  phase_t        phase;
  logic [RW-1:0] acc_nxt;
  logic [RW-1:0] res_q;

  seqmul_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .load(load), .step_en(step_en),
    .fin(fin), .phase(phase), .busy(busy), .done(done)
  );

  seqmul_accum #(.HW(HW)) u_acc (
    .clk(clk), .rst(rst), .load(load), .step_en(step_en), .fin(fin),
    .phase(phase), .sgn_in(signed_mode), .a_in(op_a), .b_in(op_b),
    .acc_nxt(acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)      res_q <= '0;
    else if (fin) res_q <= acc_nxt;
  end

  assign res_b3 = res_q[4*HW-1:3*HW];
  assign res_b2 = res_q[3*HW-1:2*HW];
  assign res_b1 = res_q[2*HW-1:HW];
  assign res_b0 = res_q[HW-1:0];

  a_r8_res_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(res_q));
endmodule

// File: tb/seqmul16_tb.sv
module seqmul16_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        signed_mode;
  logic [15:0] op_a, op_b;
  logic        busy, done;
  logic [7:0]  res_b3, res_b2, res_b1, res_b0;

  always #2.5 clk = ~clk;

  seqmul16 u_dut (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
    .res_b3(res_b3), .res_b2(res_b2), .res_b1(res_b1), .res_b0(res_b0)
  );

  typedef struct {
    logic [15:0] a;
    logic [15:0] b;
    logic        sgn;
    logic [31:0] exp;
  } item_t;

  item_t       sb_q[$];
  int          total = 0;
  int          bad = 0;
  int          busy_cnt = 0;
  logic [31:0] last_res = 32'h0;
  logic        mon_on = 1'b0;
  logic        finished = 1'b0;

  function automatic logic [31:0] ref_prod(logic [15:0] a, logic [15:0] b, logic s);
    int sa, sb;
    if (s) begin
      sa = $signed(a);
      sb = $signed(b);
      return 32'(sa * sb);
    end
    return {16'h0, a} * {16'h0, b};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: wait until idle, launch, optionally disturb the busy window.
  task automatic issue(logic [15:0] a, logic [15:0] b, logic s, bit disturb);
    item_t it;
    while (busy) @(negedge clk);
    op_a = a; op_b = b; signed_mode = s; start = 1'b1;
    it.a = a; it.b = b; it.sgn = s; it.exp = ref_prod(a, b, s);
    sb_q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R6: stimulus while busy must not affect the pending product
      op_a = ~a; op_b = b ^ 16'h5A5A; signed_mode = ~s; start = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard on each completion.
  always @(negedge clk) begin
    if (mon_on) begin
      logic [31:0] r;
      r = {res_b3, res_b2, res_b1, res_b0};
      if (done) begin
        check("R5 busy length", 32'(busy_cnt), 32'd5);
        check("R7 busy low with done", {31'h0, busy}, 32'h0);
        if (sb_q.size() == 0) begin
          check("R6 no extra completion", 32'h1, 32'h0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          if (it.sgn) check("R3 signed product", r, it.exp);
          else        check("R2 unsigned product", r, it.exp);
          check("R4 upper byte", {24'h0, res_b3}, {24'h0, it.exp[31:24]});
        end
        last_res = r;
        busy_cnt = 0;
      end else begin
        if (busy) check("R8 result held", r, last_res);
        if (busy) busy_cnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] corners [5];
    corners[0] = 16'h0000; corners[1] = 16'h0001; corners[2] = 16'h7FFF;
    corners[3] = 16'h8000; corners[4] = 16'hFFFF;
    rst = 1'b1; start = 1'b0; signed_mode = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 busy", {31'h0, busy}, 32'h0);
    check("R1 done", {31'h0, done}, 32'h0);
    check("R1 result", {res_b3, res_b2, res_b1, res_b0}, 32'h0);
    mon_on = 1'b1;

    // R4: byte placement on a product with distinct bytes (0x1234*0x1000 = 0x01234000)
    issue(16'h1234, 16'h1000, 1'b0, 1'b0);
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          issue(corners[i], corners[j], s[0], 1'b0);
    for (int k = 0; k < 12; k++)
      issue(16'($urandom), 16'($urandom), k[0], 1'b1);
    for (int k = 0; k < 300; k++)
      issue(16'($urandom), 16'($urandom), 1'($urandom), 1'b0);

    while (busy || sb_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    // R6: no stray completion left from disturbed starts
    check("R6 queue drained", 32'(sb_q.size()), 32'h0);
    check("R7 done idle", {31'h0, done}, 32'h0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule